// File: doc/BRIEF.md
# Quadrature Input Spike Filter

This block sits between the three encoder pins (phase A, phase B and index) and a quadrature decoder. It removes short glitches from them. Each pin is first brought into the core clock domain through its own flop chain. While filtering is on, a channel passes a new level on to its output only after the synchronised input has held that level for a full acceptance window. The window is the programmed length plus two core clock periods. While filtering is off, the synchronised pins reach the outputs unchanged.

The filter has two settings: an enable bit and a 21-bit length. Both are loaded through a small write-only register port. One setting serves all three channels, but each channel keeps its own stability counter. A run input marks the downstream peripheral as active. While run is high, every configuration write is dropped, so the window cannot change under a running decoder. Edge detection and position counting belong to the next stage.

Top module: `qsf_spike_filter`

## Requirements
- R1: After reset, all three outputs are 0, the filter is off and the programmed length is 0.
- R2: Each pin passes through a two-flop synchroniser. With filtering off, an output follows its pin two clock edges after the pin changes.
- R3: With filtering on and length L, the acceptance window is W = L + 2 clocks. A synchronised level that differs from the output, and holds for W consecutive clocks, is copied to the output. The output therefore changes W + 2 edges after the pin does.
- R4: With filtering on, a pulse held for fewer than W clocks leaves the output unchanged.
- R5: A channel's counter restarts whenever its synchronised input returns to the output level. Several short runs whose total exceeds W, but none of which reaches W on its own, are rejected.
- R6: Only bits 20:0 of a length write are stored; bits 31:21 of the write data are ignored.
- R7: A configuration write made while run_en is 1 changes neither the enable bit nor the length.
- R8: All three channels use the same window and count independently; simultaneous changes on all pins are accepted in the same cycle.
- R9: The smallest length, 0, gives a two-clock window: a one-clock pulse is rejected and a two-clock pulse is accepted.
- R10: Address 0 holds the enable in write-data bit 0, with bits 31:1 ignored; address 1 holds the length. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Peripheral running; blocks configuration writes |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = enable register, 1 = length register |
| cfg_wdata | input | 32 | Write data |
| pha_in | input | 1 | Asynchronous phase A pin |
| phb_in | input | 1 | Asynchronous phase B pin |
| idx_in | input | 1 | Asynchronous index pin |
| pha_out | output | 1 | Conditioned phase A |
| phb_out | output | 1 | Conditioned phase B |
| idx_out | output | 1 | Conditioned index |

## Verification
Three latencies matter. A pin change reaches the output two edges later with filtering off, and W + 2 edges later with filtering on. A configuration write applies from the edge that samples it. The bench drives pins and writes on falling edges and samples outputs on falling edges. This places each directed check exactly one falling edge before and one falling edge after the edge where a change is due, so a latency that is off by one in either direction fails a check. A behavioural model, built from pin-history queues and run-length integers, predicts every output on every cycle. It also covers a randomised phase that mixes pin activity, locked writes and window changes.

// File: rtl/qsf_pkg.sv
package qsf_pkg;
  localparam int CFG_LEN_W  = 21;
  localparam int CFG_DATA_W = 32;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_LEN  = 1'b1
  } cfg_addr_e;
endpackage

// File: rtl/qsf_cfg.sv
module qsf_cfg #(
  parameter int LEN_W  = qsf_pkg::CFG_LEN_W,
  parameter int DATA_W = qsf_pkg::CFG_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              flt_en,
  output logic [LEN_W-1:0]  flt_len
);
  import qsf_pkg::*;

  logic wr_ok;
  logic wr_ctrl;
  logic wr_len;
  logic unused_wdata;

  assign wr_ok        = wr_en && !run_en;
  assign wr_ctrl      = wr_ok && (cfg_addr_e'(wr_addr) == ADDR_CTRL);
  assign wr_len       = wr_ok && (cfg_addr_e'(wr_addr) == ADDR_LEN);
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_en  <= 1'b0;
      flt_len <= '0;
    end else begin
      if (wr_ctrl) flt_en  <= wr_data[0];
      if (wr_len)  flt_len <= wr_data[LEN_W-1:0];
    end
  end

  assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(flt_en) && $stable(flt_len)));

  assert_len_truncated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !run_en && wr_addr) |=> (flt_len == $past(wr_data[LEN_W-1:0])));

  assert_ctrl_bit0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !run_en && !wr_addr) |=> (flt_en == $past(wr_data[0])));
endmodule

// File: rtl/qsf_sync.sv
module qsf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/qsf_chan.sv
module qsf_chan #(
  parameter int LEN_W = qsf_pkg::CFG_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             flt_en,
  input  logic [LEN_W-1:0] flt_len,
  output logic             filt_o,
  output logic             accept_o
);
  localparam int CNT_W = LEN_W + 1;

  function automatic logic [CNT_W-1:0] window_of(input logic [LEN_W-1:0] len);
    return {1'b0, len} + CNT_W'(2);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] win;
  logic             filt_q;
  logic             differ;
  logic             hit;

  assign win      = window_of(flt_len);
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign differ   = (sync_i != filt_q);
  assign hit      = differ && (cnt_inc >= win);
  assign accept_o = flt_en && hit;
  assign filt_o   = filt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!flt_en) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else if (!differ) begin
      cnt_q  <= '0;
    end else if (hit) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_inc;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (filt_q == 1'b0 && cnt_q == '0));

  assert_bypass_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_en |=> (filt_q == $past(sync_i)));

  assert_accept_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (filt_q == $past(sync_i) && cnt_q == '0));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && $stable(flt_len)) |-> (cnt_q < win));

  assert_hold_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && !accept_o) |=> $stable(filt_q));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && !differ) |=> (cnt_q == '0));
endmodule

// File: rtl/qsf_spike_filter.sv
module qsf_spike_filter #(
  parameter int LEN_W       = qsf_pkg::CFG_LEN_W,
  parameter int DATA_W      = qsf_pkg::CFG_DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              cfg_wr_en,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              pha_in,
  input  logic              phb_in,
  input  logic              idx_in,
  output logic              pha_out,
  output logic              phb_out,
  output logic              idx_out
);
  localparam int N_CH = 3;

  logic             flt_en;
  logic [LEN_W-1:0] flt_len;
  logic [N_CH-1:0]  pin_raw;
  logic [N_CH-1:0]  pin_sync;
  logic [N_CH-1:0]  pin_filt;
  logic [N_CH-1:0]  pin_accept;
  logic [N_CH-1:0]  pin_out;

  assign pin_raw = {idx_in, phb_in, pha_in};

  qsf_cfg #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .flt_en  (flt_en),
    .flt_len (flt_len)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    qsf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_raw[ch]),
      .q_o   (pin_sync[ch])
    );

    qsf_chan #(.LEN_W(LEN_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (pin_sync[ch]),
      .flt_en   (flt_en),
      .flt_len  (flt_len),
      .filt_o   (pin_filt[ch]),
      .accept_o (pin_accept[ch])
    );
  end

  assign pin_out = flt_en ? pin_filt : pin_sync;
  assign pha_out = pin_out[0];
  assign phb_out = pin_out[1];
  assign idx_out = pin_out[2];

  assert_accept_needs_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_accept & ~(pin_sync ^ pin_filt)) == '0));

  assert_out_stable_filtered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && pin_accept == '0) |=> (flt_en ? $stable(pin_filt) : 1'b1));
endmodule

// File: tb/qsf_spike_filter_tb.sv
module qsf_spike_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        pha_in = 1'b0, phb_in = 1'b0, idx_in = 1'b0;
  logic        pha_out, phb_out, idx_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qsf_spike_filter u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pha_in(pha_in), .phb_in(phb_in), .idx_in(idx_in),
    .pha_out(pha_out), .phb_out(phb_out), .idx_out(idx_out)
  );

  // Behavioural reference: pin history queues and run lengths
  bit          ref_en;
  int unsigned ref_len;
  bit          hist[3][$];
  bit          ref_held[3];
  int unsigned ref_run[3];

  function automatic bit pin_of(int ch);
    return (ch == 0) ? pha_in : (ch == 1) ? phb_in : idx_in;
  endfunction

  function automatic bit sync_of(int ch);
    return hist[ch][0];
  endfunction

  function automatic bit ref_out(int ch);
    return ref_en ? ref_held[ch] : sync_of(ch);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_en  = 1'b0;
      ref_len = 0;
      for (int c = 0; c < 3; c++) begin
        hist[c] = '{1'b0, 1'b0};
        ref_held[c] = 1'b0;
        ref_run[c] = 0;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        bit s;
        s = sync_of(c);
        if (!ref_en) begin
          ref_held[c] = s;
          ref_run[c] = 0;
        end else if (s == ref_held[c]) begin
          ref_run[c] = 0;
        end else if (ref_run[c] + 1 >= ref_len + 2) begin
          ref_held[c] = s;
          ref_run[c] = 0;
        end else begin
          ref_run[c]++;
        end
        void'(hist[c].pop_front());
        hist[c].push_back(pin_of(c));
      end
      if (cfg_wr_en && !run_en) begin
        if (cfg_addr) ref_len = cfg_wdata[LEN_W-1:0];
        else          ref_en  = cfg_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] act;
      act = {idx_out, phb_out, pha_out};
      for (int c = 0; c < 3; c++) begin
        n_chk++;
        if (act[c] !== ref_out(c)) begin
          n_fail++;
          $display("FAIL R3 cycle model ch%0d: actual %0b expected %0b at %0t",
                   c, act[c], ref_out(c), $time);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {idx_out, phb_out, pha_out};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %03b expected %03b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    cfg_wr_en = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    step(1);
    cfg_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    chk("R1 reset outputs", 3'b000);
    rst_n = 1'b1;
    step(1);
    chk("R1 after release", 3'b000);

    // R2: bypass latency of two edges
    pha_in = 1'b1;
    step(1); chk("R2 bypass one edge", 3'b000);
    step(1); chk("R2 bypass two edges", 3'b001);

    // R10: length 3 (W=5), enable via bit 0
    wr(1'b1, 32'd3);
    wr(1'b0, 32'd1);
    run_en = 1'b1;
    step(4);
    chk("R10 enable keeps level", 3'b001);
    pha_in = 1'b0;
    step(6); chk("R3 before window", 3'b001);
    step(1); chk("R3 at window", 3'b000);

    // R4: 4-clock pulse rejected, then 5-clock pulse accepted
    phb_in = 1'b1; step(4); phb_in = 1'b0;
    step(12); chk("R4 short pulse rejected", 3'b000);
    phb_in = 1'b1; step(5); phb_in = 1'b0;
    step(1); chk("R3 full pulse pending", 3'b000);
    step(1); chk("R3 full pulse accepted", 3'b010);
    step(10); chk("R3 pulse release accepted", 3'b000);

    // R5: runs of 3 and 4 separated by one clock
    idx_in = 1'b1; step(3); idx_in = 1'b0; step(1);
    idx_in = 1'b1; step(4); idx_in = 1'b0;
    step(12); chk("R5 split runs rejected", 3'b000);

    // R7: writes while running are dropped
    wr(1'b1, 32'd0);
    wr(1'b0, 32'd0);
    pha_in = 1'b1; step(2); chk("R7 no bypass while locked", 3'b000);
    pha_in = 1'b0; step(2); chk("R7 window unchanged", 3'b000);
    step(8);

    // R6: upper bits of length dropped -> L=1, W=3
    run_en = 1'b0;
    wr(1'b1, 32'hFFE0_0001);
    pha_in = 1'b1;
    step(4); chk("R6 before window", 3'b000);
    step(1); chk("R6 at window", 3'b001);
    pha_in = 1'b0; step(8); chk("R6 release", 3'b000);

    // R9: minimum window of two
    wr(1'b1, 32'd0);
    phb_in = 1'b1; step(1); phb_in = 1'b0;
    step(8); chk("R9 one-clock pulse rejected", 3'b000);
    phb_in = 1'b1;
    step(3); chk("R9 before window", 3'b000);
    step(1); chk("R9 two-clock accepted", 3'b010);
    phb_in = 1'b0; step(8);

    // R8: all channels together
    {idx_in, phb_in, pha_in} = 3'b111;
    step(3); chk("R8 all pending", 3'b000);
    step(1); chk("R8 all accepted", 3'b111);
    wr(1'b1, 32'd5);
    step(2);
    {idx_in, phb_in, pha_in} = 3'b000;
    step(8); chk("R8 wide window pending", 3'b111);
    step(1); chk("R8 wide window accepted", 3'b000);

    // R10: only bit 0 of the control write counts
    wr(1'b0, 32'hFFFF_FFFE);
    pha_in = 1'b1;
    step(1); chk("R10 disabled one edge", 3'b000);
    step(1); chk("R10 disabled two edges", 3'b001);
    pha_in = 1'b0; step(4);

    // Randomised phase, compared every clock against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4)       wr(1'b1, {$urandom} & 32'hFFE0_0007);
      else if (r < 7)  wr(1'b0, $urandom);
      else if (r < 10) begin run_en = ~run_en; step(1); end
      else begin
        {idx_in, phb_in, pha_in} = {idx_in, phb_in, pha_in} ^ 3'($urandom_range(0, 7));
        step($urandom_range(1, 9));
      end
    end
    finish_run();
  end
endmodule